// File: doc/BRIEF.md
# Paging Call Record Formatter

This block turns decoded paging codewords into fixed three-byte records for a message buffer. Each beat offered on the input stream is one codeword. The upstream logic has already corrected it and made the termination decision, and it labels the beat with a kind. The kinds are:

- an address that matched an enabled user address, which starts a call;
- a message codeword;
- a terminate request.

The formatter places the sync identifier, the address identifier, the data-fail and forced-termination flags, the function bits, the payload bits and the three-bit error type at fixed bit positions. It then streams the record out one byte at a time.

A call is one header record, zero or more message records, and one terminator record. An alert-only call is a header followed directly by a terminator. If an address beat arrives while a call is still open, the new header takes the place of the terminator, and the call stays open. Message and terminate beats that arrive while no call is open are accepted and produce nothing.

Both data interfaces use valid/ready. An input beat is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` stays low from that acceptance until the last byte of the resulting record has been taken. An output byte moves on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and `out_data` hold their values. The beat fields only need to be stable on the accepting cycle.

Top module: `call_record_fmt`

## Requirements
- R1: An accepted beat that produces a record gives exactly three bytes, first byte first. The first byte is valid in the cycle after acceptance. With `out_ready` held high, one byte moves per cycle.
- R2: `in_ready` is low while any byte of a record is still pending. When `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable in the next cycle.
- R3: An address beat (`in_kind`=0) writes header bytes 1 and 2 as {0, S[2:0], A[2:0], DF} and {0, S[2:0], A[2:0], 0}. S is the sync identifier and A is the address identifier.
- R4: Header byte 3 is {0, 0, F0, F1, E[2:0], 0}, where F0 = `in_data[1]` and F1 = `in_data[0]`. E[2] is forced to 0 when the header starts a concatenated call, that is, when it arrives while a call is open.
- R5: A message beat (`in_kind`=1) during an open call writes {D[19:12]}, {D[11:4]} and {D[3:0], E[2:0], M}. D is `in_data` and M is `in_cw_flag`.
- R6: A terminate beat (`in_kind`=2) during an open call writes {FT, S, 000, DF}, {FT, S, 000, 0} and {0000, 0, E[1:0], 0}. It then closes the call.
- R7: When `in_sync_ok` is 0, the written sync identifier is 0 and DF is 1, in both headers and terminators. Otherwise DF equals `in_df`. An identifier of 7 denotes the standard sync word and is passed through unchanged.
- R8: Message and terminate beats while no call is open, and beats of kind 3, are accepted and write no byte. The call state is unchanged.
- R9: An address beat while a call is open writes only the new header, with no terminator, and the call remains open. A following message beat is therefore recorded.
- R10: During and after reset, `out_valid` is 0, `in_ready` is 1 and no call is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Codeword beat offered |
| in_ready | output | 1 | Formatter can take a beat |
| in_kind | input | 2 | 0 address, 1 message, 2 terminate request, 3 reserved |
| in_cw_flag | input | 1 | Corrected codeword flag bit, stored in message records |
| in_data | input | 20 | Message payload, or function bits in [1:0] for addresses |
| in_err | input | 3 | Error type: 000 none, 001 parity, 010 single, 011 single+parity, 101 burst+parity, 110 double, 111 uncorrectable |
| in_sync_id | input | 3 | Sync word identifier for the batch (7 = standard) |
| in_sync_ok | input | 1 | Batch sync matched a known pattern |
| in_addr_id | input | 3 | Identifier of the matched user address |
| in_df | input | 1 | Data-fail indication |
| in_ft | input | 1 | Forced-termination indication |
| out_valid | output | 1 | Record byte valid |
| out_ready | input | 1 | Buffer takes the byte |
| out_data | output | 8 | Record byte |

## Verification
On every cycle, the assertions check four things:

- the output holds under back-pressure;
- each record's full three bytes are taken before another beat is accepted;
- the leading header bit and the terminator's tail bits are zero;
- dropped beats and concatenated headers move the call state correctly.

The exact bit placement of every field only shows up in the bench's scenarios. So do the forcing of E[2] in concatenated headers and terminators, the replacement of an unknown sync identifier with 0 and DF, and recovery after a reset in mid-record. The bench compares each byte against values it derives itself.

// File: rtl/recfmt_pkg.sv
package recfmt_pkg;
  localparam int BYTE_W    = 8;
  localparam int REC_BYTES = 3;
  localparam int REC_W     = BYTE_W * REC_BYTES;
  localparam int PAY_W     = 20;
  localparam int ID_W      = 3;
  localparam int ERR_W     = 3;
  localparam int CNT_W     = $clog2(REC_BYTES + 1);

  typedef enum logic [1:0] {
    K_ADDR = 2'd0,
    K_MSG  = 2'd1,
    K_TERM = 2'd2,
    K_RSVD = 2'd3
  } kind_e;
endpackage

// File: rtl/recfmt_pack.sv
module recfmt_pack
  import recfmt_pkg::*;
(
  input  kind_e              kind,
  input  logic               cw_flag,
  input  logic [PAY_W-1:0]   data,
  input  logic [ERR_W-1:0]   err,
  input  logic [ID_W-1:0]    sync_id,
  input  logic               sync_ok,
  input  logic [ID_W-1:0]    addr_id,
  input  logic               df,
  input  logic               ft,
  input  logic               call_open,
  output logic [REC_W-1:0]   rec,
  output logic               emit
);
  logic [ID_W-1:0]  sid_w;
  logic             df_w;
  logic [ERR_W-1:0] err_lo;

  // unknown batch sync: identifier cleared, data-fail raised (R7)
  assign sid_w  = sync_ok ? sync_id : '0;
  assign df_w   = df | ~sync_ok;
  assign err_lo = {1'b0, err[ERR_W-2:0]};

  always_comb begin
    rec  = '0;
    emit = 1'b0;
    case (kind)
      K_ADDR: begin
        emit = 1'b1;
        rec  = {1'b0, sid_w, addr_id, df_w,
                1'b0, sid_w, addr_id, 1'b0,
                2'b00, data[1], data[0],
                (call_open ? err_lo : err), 1'b0};
      end
      K_MSG: begin
        emit = call_open;
        rec  = {data, err, cw_flag};
      end
      K_TERM: begin
        emit = call_open;
        rec  = {ft, sid_w, 3'b000, df_w,
                ft, sid_w, 3'b000, 1'b0,
                4'b0000, err_lo, 1'b0};
      end
      default: begin
        emit = 1'b0;
        rec  = '0;
      end
    endcase
  end
endmodule

// File: rtl/recfmt_seq.sv
module recfmt_seq
  import recfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  kind_e             kind,
  input  logic [REC_W-1:0]  rec,
  input  logic              emit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              call_open
);
  logic [REC_W-1:0] sreg;
  logic [CNT_W-1:0] left;
  kind_e            cur_kind;
  logic             fire;
  logic             take;

  assign in_ready  = (left == '0);
  assign out_valid = (left != '0);
  assign out_data  = sreg[REC_W-1 -: BYTE_W];
  assign fire      = in_valid & in_ready;
  assign take      = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg      <= '0;
      left      <= '0;
      cur_kind  <= K_RSVD;
      call_open <= 1'b0;
    end else if (fire) begin
      if (emit) begin
        sreg     <= rec;
        left     <= CNT_W'(REC_BYTES);
        cur_kind <= kind;
      end
      if (kind == K_ADDR)      call_open <= 1'b1;
      else if (kind == K_TERM) call_open <= 1'b0;
    end else if (take) begin
      sreg <= sreg << BYTE_W;
      left <= left - 1'b1;
    end
  end

  // checker state: bytes taken since the last emitting acceptance
  logic [CNT_W-1:0] nbytes;
  logic             started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbytes  <= '0;
      started <= 1'b0;
    end else if (fire && emit) begin
      nbytes  <= '0;
      started <= 1'b1;
    end else if (take) begin
      nbytes <= nbytes + 1'b1;
    end
  end

  a_r1_three_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && started) |-> (nbytes == CNT_W'(REC_BYTES)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r3_hdr_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cur_kind == K_ADDR && left == CNT_W'(REC_BYTES)) |-> !out_data[BYTE_W-1]);

  a_r6_term_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cur_kind == K_TERM && left == CNT_W'(1)) |-> (out_data[BYTE_W-1:3] == '0));

  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind != K_ADDR && !call_open) |=> (!out_valid && !call_open));

  a_r9_open: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == K_ADDR) |=> call_open);
endmodule

// File: rtl/call_record_fmt.sv
module call_record_fmt
  import recfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic              in_cw_flag,
  input  logic [PAY_W-1:0]  in_data,
  input  logic [ERR_W-1:0]  in_err,
  input  logic [ID_W-1:0]   in_sync_id,
  input  logic              in_sync_ok,
  input  logic [ID_W-1:0]   in_addr_id,
  input  logic              in_df,
  input  logic              in_ft,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data
);
  kind_e            kind;
  logic [REC_W-1:0] rec;
  logic             emit;
  logic             call_open;

  assign kind = kind_e'(in_kind);

  recfmt_pack u_pack (
    .kind      (kind),
    .cw_flag   (in_cw_flag),
    .data      (in_data),
    .err       (in_err),
    .sync_id   (in_sync_id),
    .sync_ok   (in_sync_ok),
    .addr_id   (in_addr_id),
    .df        (in_df),
    .ft        (in_ft),
    .call_open (call_open),
    .rec       (rec),
    .emit      (emit)
  );

  recfmt_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .kind      (kind),
    .rec       (rec),
    .emit      (emit),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .call_open (call_open)
  );
endmodule

// File: tb/test_call_record_fmt.sv
module test_call_record_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_kind = 2'd0;
  logic        in_cw_flag = 1'b0;
  logic [19:0] in_data = '0;
  logic [2:0]  in_err = '0;
  logic [2:0]  in_sync_id = '0;
  logic        in_sync_ok = 1'b0;
  logic [2:0]  in_addr_id = '0;
  logic        in_df = 1'b0;
  logic        in_ft = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  call_record_fmt i_call_record_fmt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_cw_flag(in_cw_flag), .in_data(in_data),
    .in_err(in_err), .in_sync_id(in_sync_id), .in_sync_ok(in_sync_ok),
    .in_addr_id(in_addr_id), .in_df(in_df), .in_ft(in_ft),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        flag;
    logic [19:0] data;
    logic [2:0]  err;
    logic [2:0]  sid;
    logic        sok;
    logic [2:0]  rid;
    logic        df;
    logic        ft;
    logic        emit;
    logic [23:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 1'b1, 20'h11111, 3'd0, 3'd7, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 24'h000000}, // R8 msg, no call
    '{2'd2, 1'b0, 20'h00000, 3'd0, 3'd7, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 24'h000000}, // R8 term, no call
    '{2'd0, 1'b0, 20'h00002, 3'd2, 3'd7, 1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 24'h747424}, // R3 header
    '{2'd1, 1'b1, 20'hABCDE, 3'd6, 3'd7, 1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 24'hABCDED}, // R5 message
    '{2'd1, 1'b0, 20'h12345, 3'd7, 3'd7, 1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 24'h12345E}, // R5 flag 0
    '{2'd0, 1'b0, 20'h00003, 3'd6, 3'd3, 1'b1, 3'd5, 1'b1, 1'b0, 1'b1, 24'h3B3A34}, // R4 R9 concat
    '{2'd2, 1'b0, 20'h00000, 3'd5, 3'd7, 1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 24'hF1F002}, // R6 terminator
    '{2'd1, 1'b1, 20'hFFFFF, 3'd0, 3'd7, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 24'h000000}, // R8 after close
    '{2'd0, 1'b0, 20'h00001, 3'd3, 3'd6, 1'b0, 3'd1, 1'b0, 1'b0, 1'b1, 24'h030216}, // R7 header
    '{2'd2, 1'b0, 20'h00000, 3'd7, 3'd7, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 24'h010006}, // R7 terminator
    '{2'd3, 1'b1, 20'hFFFFF, 3'd7, 3'd7, 1'b1, 3'd7, 1'b1, 1'b1, 1'b0, 24'h000000}, // R8 reserved kind
    '{2'd0, 1'b0, 20'h00000, 3'd0, 3'd7, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 24'h707000}, // R3 alert-only header
    '{2'd2, 1'b0, 20'h00000, 3'd1, 3'd4, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 24'h404002}  // R6 alert-only end
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1, 7, 10: return "R8";
      2, 11:       return "R3 R4";
      3, 4:        return "R5";
      5:           return "R4 R9";
      6, 12:       return "R6";
      default:     return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_kind = v.kind; in_cw_flag = v.flag; in_data = v.data; in_err = v.err;
    in_sync_id = v.sid; in_sync_ok = v.sok; in_addr_id = v.rid;
    in_df = v.df; in_ft = v.ft;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect(input vec_t v, input string tag);
    if (v.emit) begin
      for (int b = 0; b < 3; b++) begin
        chk($sformatf("R1 %s valid byte%0d", tag, b), {31'd0, out_valid}, 32'd1);
        chk($sformatf("R1 %s data byte%0d", tag, b), {24'd0, out_data}, {24'd0, v.exp[23-8*b -: 8]});
        @(negedge clk);
      end
      chk($sformatf("R2 %s ready after record", tag), {31'd0, in_ready}, 32'd1);
    end else begin
      for (int c = 0; c < 3; c++) begin
        chk($sformatf("%s no byte", tag), {31'd0, out_valid}, 32'd0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    vec_t bp;
    vec_t mv;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R10 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out_valid after reset", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      collect(VEC[i], tag_of(i));
    end

    // R2: back-pressure on the header of a new call
    bp = VEC[2];
    out_ready = 1'b0;
    drive(bp);
    for (int k = 0; k < 3; k++) begin
      chk("R2 held valid", {31'd0, out_valid}, 32'd1);
      chk("R2 held data", {24'd0, out_data}, 32'h74);
      chk("R2 in_ready low while busy", {31'd0, in_ready}, 32'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    collect(bp, "R2 R3");

    // R9: call opened above, message is recorded
    mv = VEC[3];
    drive(mv);
    collect(mv, "R9");

    // R10: reset mid-record clears the call
    drive(VEC[2]);
    chk("R10 busy before reset", {31'd0, out_valid}, 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 out_valid cleared", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    drive(VEC[3]);
    collect(VEC[0], "R10 R8 closed after reset");

    finish_run();
  end
endmodule